// File: doc/BRIEF.md
# Command-Word Addressed Byte Memory

This block is a single-port byte memory driven by a stream of command words. Every word is two opcode bits above an eight-bit field. Depending on the opcode, the field is loaded into a held write pointer, stored as data at that pointer, or loaded into a held read pointer. The fourth opcode starts a read at the held read pointer and ignores the field. The byte that was read appears on a dedicated output one clock later, together with a one-cycle valid flag.

The block expects a front end that assembles serial traffic into parallel words and presents one command per clock, qualified by a strobe. Because the two pointers are independent registers loaded by their own commands, a sequence of data writes and read requests can reuse an address that was set once. Each pointer is wide enough for the full address. Every pointer value is reduced modulo the memory depth before it indexes the array. A reset clears the pointers and the output stage but leaves the stored bytes as they are.

Top module: `cmdword_ram`

## Requirements
- R1: A synchronous active-low reset clears rd_valid and rd_data to 0 and both held pointers to 0. After reset and before any pointer is loaded, a data write goes to location 0 and a read request reads location 0.
- R2: While cmd_valid is low, cmd_word has no effect on the memory, the pointers or the outputs.
- R3: An accepted word with cmd_word[9:8] = 2'b00 loads cmd_word[AW-1:0] into the write pointer.
- R4: An accepted word with cmd_word[9:8] = 2'b01 stores cmd_word[7:0] at the write pointer and leaves the write pointer unchanged.
- R5: An accepted word with cmd_word[9:8] = 2'b10 loads cmd_word[AW-1:0] into the read pointer.
- R6: An accepted word with cmd_word[9:8] = 2'b11 places the byte at the read pointer on rd_data in the next cycle. Its field cmd_word[7:0] is ignored, and it changes no pointer and no memory byte.
- R7: rd_valid is high in exactly those cycles that follow an accepted read request. Back-to-back requests keep it high for one cycle per request.
- R8: rd_data keeps its value in every cycle that does not follow an accepted read request.
- R9: A read request accepted in the cycle right after a data write to the same location returns the newly written byte.
- R10: Both pointers index the array modulo DEPTH, so pointer values p and p + DEPTH name the same location.
- R11: Reset does not alter the stored bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Qualifies cmd_word in this cycle |
| cmd_word | input | FW+2 | Opcode in the top two bits, field below |
| rd_data | output | FW | Byte returned by the latest read request |
| rd_valid | output | 1 | High for one cycle after each accepted read request |

## Verification
Two functions meet in one cycle when a read request arrives on the clock right after a data write to the same location. The array update and the read-port lookup then sit on adjacent edges, and the expected byte is the new one. The bench provokes this by loading both pointers with one address, issuing a write and then a read request on consecutive cycles. It judges the result against a bench-side byte array. A second overlap is the rd_valid pulse of one read request falling in the same cycle as the next request. Back-to-back requests check that the flag stays high and that rd_data steps to each new byte.

// File: rtl/cmdram_pkg.sv
package cmdram_pkg;

    typedef enum logic [1:0] {
        OP_LOAD_WPTR = 2'b00,
        OP_STORE     = 2'b01,
        OP_LOAD_RPTR = 2'b10,
        OP_FETCH     = 2'b11
    } cmd_op_e;

    typedef struct packed {
        logic load_wptr;
        logic store;
        logic load_rptr;
        logic fetch;
    } cmd_strobe_t;

endpackage

// File: rtl/cmdram_decode.sv
module cmdram_decode
    import cmdram_pkg::*;
#(
    parameter int FW = 8
) (
    input  logic          cmd_valid,
    input  logic [FW+1:0] cmd_word,
    output cmd_strobe_t   strobe,
    output logic [FW-1:0] field
);

    cmd_op_e op;

    always_comb begin
        op     = cmd_op_e'(cmd_word[FW+1:FW]);
        field  = cmd_word[FW-1:0];
        strobe = '0;
        if (cmd_valid) begin
            unique case (op)
                OP_LOAD_WPTR: strobe.load_wptr = 1'b1;
                OP_STORE:     strobe.store     = 1'b1;
                OP_LOAD_RPTR: strobe.load_rptr = 1'b1;
                OP_FETCH:     strobe.fetch     = 1'b1;
                default:      strobe           = '0;
            endcase
        end
    end

    always_comb begin
        assert_one_action_R2: assert ($onehot0(strobe));
    end

endmodule

// File: rtl/cmdram_ptrs.sv
module cmdram_ptrs
    import cmdram_pkg::*;
#(
    parameter int AW = 8,
    parameter int FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cmd_strobe_t   strobe,
    input  logic [FW-1:0] field,
    output logic [AW-1:0] wptr,
    output logic [AW-1:0] rptr
);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
    } ptr_state_t;

    ptr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (strobe.load_wptr) begin
            st_d.wptr = field[AW-1:0];
        end
        if (strobe.load_rptr) begin
            st_d.rptr = field[AW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wptr = st_q.wptr;
    assign rptr = st_q.rptr;

    assert_wptr_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        strobe.load_wptr |=> (wptr == $past(field[AW-1:0])));

    assert_wptr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe.load_wptr |=> $stable(wptr));

    assert_rptr_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        strobe.load_rptr |=> (rptr == $past(field[AW-1:0])));

    assert_rptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe.load_rptr |=> $stable(rptr));

endmodule

// File: rtl/cmdram_array.sv
module cmdram_array #(
    parameter int DEPTH = 256,
    parameter int AW    = 8,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wptr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] rptr,
    output logic [DW-1:0] rdata
);

    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam bit POW2 = (DEPTH == (1 << IW)) && (AW >= IW);

    logic [IW-1:0] widx;
    logic [IW-1:0] ridx;

    generate
        if (POW2) begin : g_slice
            assign widx = wptr[IW-1:0];
            assign ridx = rptr[IW-1:0];
        end else begin : g_modulo
            logic [31:0] wmod;
            logic [31:0] rmod;
            always_comb begin
                wmod = 32'(wptr) % 32'(DEPTH);
                rmod = 32'(rptr) % 32'(DEPTH);
            end
            assign widx = wmod[IW-1:0];
            assign ridx = rmod[IW-1:0];
        end
    endgenerate

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[widx] <= wdata;
        end
    end

    assign rdata = mem[ridx];

    always_comb begin
        assert_index_in_range_R10: assert (32'(ridx) < 32'(DEPTH) && 32'(widx) < 32'(DEPTH));
    end

endmodule

// File: rtl/cmdram_rdout.sv
module cmdram_rdout #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch,
    input  logic [DW-1:0] rdata,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);

    typedef struct packed {
        logic          valid;
        logic [DW-1:0] data;
    } out_state_t;

    out_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = fetch;
        if (fetch) begin
            st_d.data = rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data  = st_q.data;
    assign rd_valid = st_q.valid;

    assert_valid_after_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fetch |=> rd_valid);

    assert_valid_low_otherwise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch |=> !rd_valid);

    assert_data_follows_array_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fetch |=> (rd_data == $past(rdata)));

    assert_data_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch |=> $stable(rd_data));

endmodule

// File: rtl/cmdword_ram.sv
module cmdword_ram
    import cmdram_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = 8,
    parameter int FW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [FW+1:0] cmd_word,
    output logic [FW-1:0] rd_data,
    output logic          rd_valid
);

    cmd_strobe_t   strobe;
    logic [FW-1:0] field;
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic [FW-1:0] rdata;

    cmdram_decode #(.FW(FW)) u_decode (
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .strobe    (strobe),
        .field     (field)
    );

    cmdram_ptrs #(.AW(AW), .FW(FW)) u_ptrs (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (strobe),
        .field  (field),
        .wptr   (wptr),
        .rptr   (rptr)
    );

    cmdram_array #(.DEPTH(DEPTH), .AW(AW), .DW(FW)) u_array (
        .clk   (clk),
        .wr_en (strobe.store),
        .wptr  (wptr),
        .wdata (field),
        .rptr  (rptr),
        .rdata (rdata)
    );

    cmdram_rdout #(.DW(FW)) u_rdout (
        .clk      (clk),
        .rst_n    (rst_n),
        .fetch    (strobe.fetch),
        .rdata    (rdata),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    assert_idle_no_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !rd_valid);

endmodule

// File: tb/tb_cmdword_ram.sv
module tb_cmdword_ram;

    localparam int DEPTH = 16;
    localparam int AW    = 6;
    localparam int FW    = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [FW+1:0] cmd_word = '0;
    logic [FW-1:0] rd_data;
    logic          rd_valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [FW-1:0] m_mem [DEPTH];
    int            m_wptr = 0;
    int            m_rptr = 0;
    logic [FW-1:0] m_data = '0;
    logic          m_valid = 1'b0;

    always #10 clk = ~clk;

    cmdword_ram #(.DEPTH(DEPTH), .AW(AW), .FW(FW)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

    task automatic check(input string req);
        n_checks++;
        if (rd_valid !== m_valid || rd_data !== m_data) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b data=%02h, expected valid=%0b data=%02h",
                     req, rd_valid, rd_data, m_valid, m_data);
        end
    endtask

    // Called at a falling edge; drives one word, lets one rising edge pass,
    // updates the model and compares at the next falling edge.
    task automatic apply(input bit v, input logic [1:0] op, input logic [7:0] f,
                         input string req);
        cmd_valid = v;
        cmd_word  = {op, f};
        @(posedge clk);
        m_valid = 1'b0;
        if (v) begin
            case (op)
                2'b00: m_wptr = int'(f) % (1 << AW);
                2'b01: m_mem[m_wptr % DEPTH] = f;
                2'b10: m_rptr = int'(f) % (1 << AW);
                default: begin
                    m_data  = m_mem[m_rptr % DEPTH];
                    m_valid = 1'b1;
                end
            endcase
        end
        @(negedge clk);
        check(req);
    endtask

    task automatic do_reset();
        rst_n     = 1'b0;
        cmd_valid = 1'b0;
        repeat (2) @(posedge clk);
        m_wptr  = 0;
        m_rptr  = 0;
        m_data  = '0;
        m_valid = 1'b0;
        @(negedge clk);
        check("R1");
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        @(negedge clk);
        do_reset();

        // R1: pointers start at 0
        apply(1'b1, 2'b01, 8'hA5, "R1");
        apply(1'b1, 2'b11, 8'h00, "R1");

        // R3, R4: fill every location through distinct pointer values
        for (int a = 0; a < DEPTH; a++) begin
            apply(1'b1, 2'b00, 8'(a), "R3");
            apply(1'b1, 2'b01, 8'((a * 37 + 11) & 255), "R4");
        end
        // R4: write pointer unchanged after a store
        apply(1'b1, 2'b00, 8'd9, "R3");
        apply(1'b1, 2'b01, 8'h11, "R4");
        apply(1'b1, 2'b01, 8'h22, "R4");
        apply(1'b1, 2'b10, 8'd9, "R5");
        apply(1'b1, 2'b11, 8'hFF, "R4");

        // R5, R6: read back every location; field of fetch varies
        for (int a = 0; a < DEPTH; a++) begin
            apply(1'b1, 2'b10, 8'(a), "R5");
            apply(1'b1, 2'b11, 8'(~a), "R6");
            apply(1'b0, 2'b00, 8'h00, "R8");
        end

        // R10: pointer aliasing modulo DEPTH
        for (int a = DEPTH; a < (1 << AW); a++) begin
            apply(1'b1, 2'b00, 8'(a), "R10");
            apply(1'b1, 2'b01, 8'((a * 13 + 5) & 255), "R10");
            apply(1'b1, 2'b10, 8'(a % DEPTH), "R10");
            apply(1'b1, 2'b11, 8'h5A, "R10");
            apply(1'b1, 2'b10, 8'(a), "R10");
            apply(1'b1, 2'b11, 8'hC3, "R10");
        end

        // R2: idle words of every opcode change nothing
        apply(1'b1, 2'b00, 8'd3, "R3");
        apply(1'b1, 2'b10, 8'd3, "R5");
        for (int op = 0; op < 4; op++) begin
            apply(1'b0, 2'(op), 8'd7, "R2");
            apply(1'b0, 2'(op), 8'hEE, "R2");
        end
        apply(1'b1, 2'b11, 8'h00, "R2");
        apply(1'b1, 2'b01, 8'h66, "R2");
        apply(1'b1, 2'b11, 8'h00, "R2");
        apply(1'b1, 2'b10, 8'd7, "R2");
        apply(1'b1, 2'b11, 8'h00, "R2");

        // R6: fetch field ignored; memory untouched
        apply(1'b1, 2'b10, 8'd4, "R5");
        for (int k = 0; k < 4; k++) apply(1'b1, 2'b11, 8'(k * 64 + 4), "R6");
        for (int a = 0; a < DEPTH; a++) begin
            apply(1'b1, 2'b10, 8'(a), "R6");
            apply(1'b1, 2'b11, 8'h00, "R6");
        end

        // R7, R8: back-to-back fetches with changing pointer in between
        apply(1'b1, 2'b10, 8'd2, "R5");
        apply(1'b1, 2'b11, 8'h00, "R7");
        apply(1'b1, 2'b11, 8'h00, "R7");
        apply(1'b1, 2'b10, 8'd8, "R7");
        apply(1'b1, 2'b11, 8'h00, "R7");
        apply(1'b0, 2'b11, 8'h00, "R7");
        apply(1'b1, 2'b00, 8'd1, "R8");
        apply(1'b1, 2'b01, 8'h99, "R8");

        // R9: store then fetch of the same location on consecutive cycles
        for (int a = 0; a < DEPTH; a++) begin
            apply(1'b1, 2'b10, 8'(a), "R9");
            apply(1'b1, 2'b00, 8'(a + DEPTH), "R9");
            apply(1'b1, 2'b01, 8'((a * 91 + 7) & 255), "R9");
            apply(1'b1, 2'b11, 8'h00, "R9");
        end

        // R11: contents survive reset; R1: pointers back at 0
        do_reset();
        apply(1'b1, 2'b11, 8'h00, "R1");
        for (int a = 0; a < DEPTH; a++) begin
            apply(1'b1, 2'b10, 8'(a), "R11");
            apply(1'b1, 2'b11, 8'h00, "R11");
        end

        // Pseudo-random command stream
        lfsr = 16'hACE1;
        for (int i = 0; i < 4000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            apply(lfsr[11:10] != 2'b00, lfsr[9:8], lfsr[7:0], "R6");
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule